// File: doc/BRIEF.md
# Dual-Port Word Memory with Cross-Port Mailbox Interrupts

This block is a synchronous true dual-port memory of 16-bit words, with a left and a right port that each read or write any location in any cycle. Every port has an active-low chip select, a write strobe (low = write, high = read), an active-low output enable and active-low upper and lower byte selects. A write changes only the byte lanes that are selected. A read returns its word one clock after the access. Read data appears only on the selected lanes, and only while that port's output enable is low. At the target size (ADDR_W = 13) the array holds 8192 words.

The two highest word addresses serve as mailboxes between the ports. When the right port writes the second-highest word, the left interrupt goes low. The left port clears it by reading that word. The highest word works the same way in the other direction. Both mailbox words keep ordinary user data and can be read and written like any other word. Collision arbitration is not part of this block: when both ports write the same byte lane of the same word in one cycle, the left port's data is stored.

Top module: `dpram_mailbox`

## Requirements
- R1: The array holds 2**ADDR_W words of 16 bits. A word written on one port reads back unchanged on either port. Read data is valid in the cycle after the clock edge that samples the read.
- R2: A write cycle is chip select low and write strobe low. It updates bits [15:8] only if the upper select is low and bits [7:0] only if the lower select is low. With both selects high, the cycle changes nothing.
- R3: After a read cycle, drive[1] is set only for the upper lane and drive[0] only for the lower lane, each when its select was low. A lane that is not driven reads as zero.
- R4: Output enable acts combinationally on the held read. With output enable high, drive is 00 and rdata is zero. Lowering it without a clock edge presents the data. The cycle after a write never drives.
- R5: With chip select high, a port writes nothing, drives nothing and changes no interrupt flag.
- R6: l_irq_n goes low after any right-port write cycle to word 2**ADDR_W-2, and returns high after a left-port read of that word. Left writes and right reads of that word leave l_irq_n unchanged.
- R7: r_irq_n goes low after any left-port write cycle to word 2**ADDR_W-1, and returns high after a right-port read of that word. Right writes and left reads of that word leave r_irq_n unchanged.
- R8: Both mailbox words store and return the 16-bit data written to them, the same as any other word.
- R9: When a flag is set and cleared in the same cycle, the set wins and the interrupt goes low.
- R10: The asynchronous reset drives both interrupts high, both drive vectors to 00 and both rdata buses to zero. Its release is synchronized to the clock.
- R11: When both ports write the same word in one cycle, each byte lane that both ports select keeps the left port's data. A lane written by only one port takes that port's data.
- R12: A read on one port of the word that the other port writes in the same cycle returns the word's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_cs_n | input | 1 | Left chip select, active low |
| l_we_n | input | 1 | Left write strobe, low = write, high = read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper byte select, active low |
| l_lb_n | input | 1 | Left lower byte select, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, zero on lanes that are not driven |
| l_drive | output | 2 | Left lane drive enables {upper, lower} |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs_n | input | 1 | Right chip select, active low |
| r_we_n | input | 1 | Right write strobe, low = write, high = read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper byte select, active low |
| r_lb_n | input | 1 | Right lower byte select, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, zero on lanes that are not driven |
| r_drive | output | 2 | Right lane drive enables {upper, lower} |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The hardest case to reach from the ports is a single cycle in which the owner reads its mailbox while the other port writes it. Both ports must point at the same top word with opposite strobes on the same edge. The bench drives that combination on purpose and checks that the interrupt goes low (R9). In the same way, it aligns two writes to one word with overlapping and with disjoint byte lanes (R11), and a read against a write (R12). The bench uses a 32-word configuration, so every ordinary address, every write-select and read-select pairing and both mailbox words are covered. It keeps expected contents in a word model that it updates by the lane rules.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = 2;
  localparam int WORD_W    = LANE_W * NUM_LANES;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } port_op_e;

  // active-low selects to an active-high lane vector {upper, lower}
  function automatic logic [NUM_LANES-1:0] lane_sel(input logic ub_n, input logic lb_n);
    return {~ub_n, ~lb_n};
  endfunction
endpackage

// File: rtl/dpr_port_ctl.sv
`timescale 1ns/1ps
module dpr_port_ctl
  import dpr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 we_n,
  input  logic                 oe_n,
  input  logic                 ub_n,
  input  logic                 lb_n,
  input  logic [WORD_W-1:0]    mem_q,
  output logic [NUM_LANES-1:0] wr_lanes,
  output logic [NUM_LANES-1:0] rd_lanes,
  output logic [WORD_W-1:0]    rdata,
  output logic [NUM_LANES-1:0] drive
);
  logic [NUM_LANES-1:0] sel;
  port_op_e             op;
  logic [NUM_LANES-1:0] held_d, held_q;

  always_comb begin
    sel = lane_sel(ub_n, lb_n);
    op  = OP_IDLE;
    if (!cs_n && (|sel)) op = we_n ? OP_READ : OP_WRITE;
    wr_lanes = (op == OP_WRITE) ? sel : '0;
    rd_lanes = (op == OP_READ)  ? sel : '0;
    held_d   = rd_lanes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign drive = held_q & {NUM_LANES{~oe_n}};

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_out
    assign rdata[g*LANE_W +: LANE_W] = drive[g] ? mem_q[g*LANE_W +: LANE_W] : '0;
  end

  // R5: a deselected port drives nothing on the following cycle
  p_idle_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (drive == '0));
  // R4: a write cycle never leads to driven data
  p_write_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=> (drive == '0));
  // R3: only lanes selected on the read cycle may be driven
  p_lane_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((drive & ~$past(sel)) == '0));
endmodule

// File: rtl/dpr_mem_array.sv
`timescale 1ns/1ps
module dpr_mem_array
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    l_addr,
  input  logic [WORD_W-1:0]    l_wdata,
  input  logic [NUM_LANES-1:0] l_wr,
  input  logic                 l_rd,
  output logic [WORD_W-1:0]    l_q,
  input  logic [ADDR_W-1:0]    r_addr,
  input  logic [WORD_W-1:0]    r_wdata,
  input  logic [NUM_LANES-1:0] r_wr,
  input  logic                 r_rd,
  output logic [WORD_W-1:0]    r_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic same_addr;
  assign same_addr = (l_addr == r_addr);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] lq, rq;
    logic              r_blocked;

    assign r_blocked = l_wr[g] && same_addr;

    always_ff @(posedge clk) begin
      if (r_wr[g] && !r_blocked) bank[r_addr] <= r_wdata[g*LANE_W +: LANE_W];
      if (l_wr[g])               bank[l_addr] <= l_wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (l_rd) lq <= bank[l_addr];
    end

    always_ff @(posedge clk) begin
      if (r_rd) rq <= bank[r_addr];
    end

    assign l_q[g*LANE_W +: LANE_W] = lq;
    assign r_q[g*LANE_W +: LANE_W] = rq;

    // R11: on a shared lane of a shared word the left data is stored
    p_left_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (l_wr[g] && r_wr[g] && same_addr) |=>
        (bank[$past(l_addr)] == $past(l_wdata[g*LANE_W +: LANE_W])));
  end
endmodule

// File: rtl/dpr_mbox_flag.sv
`timescale 1ns/1ps
module dpr_mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  logic flag_d, flag_q;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign irq_n = ~flag_q;

  // R9: a set in the same cycle as a clear still asserts the interrupt
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> !irq_n);
  // R6: a clear with no set releases the interrupt
  p_clear_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> irq_n);
  // R5: with no event the interrupt holds
  p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set) |=> $stable(irq_n));
endmodule

// File: rtl/dpram_mailbox.sv
`timescale 1ns/1ps
module dpram_mailbox
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 l_cs_n,
  input  logic                 l_we_n,
  input  logic                 l_oe_n,
  input  logic                 l_ub_n,
  input  logic                 l_lb_n,
  input  logic [ADDR_W-1:0]    l_addr,
  input  logic [WORD_W-1:0]    l_wdata,
  output logic [WORD_W-1:0]    l_rdata,
  output logic [NUM_LANES-1:0] l_drive,
  output logic                 l_irq_n,
  input  logic                 r_cs_n,
  input  logic                 r_we_n,
  input  logic                 r_oe_n,
  input  logic                 r_ub_n,
  input  logic                 r_lb_n,
  input  logic [ADDR_W-1:0]    r_addr,
  input  logic [WORD_W-1:0]    r_wdata,
  output logic [WORD_W-1:0]    r_rdata,
  output logic [NUM_LANES-1:0] r_drive,
  output logic                 r_irq_n
);
  localparam int NPORT = 2;
  localparam logic [ADDR_W-1:0] MBOX_TO_L = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] MBOX_TO_R = {ADDR_W{1'b1}};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // port 0 = left, port 1 = right
  logic [NPORT-1:0]     cs_n_a, we_n_a, oe_n_a, ub_n_a, lb_n_a, irq_n_a;
  logic [ADDR_W-1:0]    addr_a     [NPORT];
  logic [ADDR_W-1:0]    mbox_a     [NPORT];
  logic [WORD_W-1:0]    q_a        [NPORT];
  logic [WORD_W-1:0]    rdata_a    [NPORT];
  logic [NUM_LANES-1:0] wr_lanes_a [NPORT];
  logic [NUM_LANES-1:0] rd_lanes_a [NPORT];
  logic [NUM_LANES-1:0] drive_a    [NPORT];

  assign cs_n_a = {r_cs_n, l_cs_n};
  assign we_n_a = {r_we_n, l_we_n};
  assign oe_n_a = {r_oe_n, l_oe_n};
  assign ub_n_a = {r_ub_n, l_ub_n};
  assign lb_n_a = {r_lb_n, l_lb_n};
  assign addr_a[0] = l_addr;
  assign addr_a[1] = r_addr;
  assign mbox_a[0] = MBOX_TO_L;
  assign mbox_a[1] = MBOX_TO_R;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int OTHER = NPORT - 1 - p;
    logic mb_set, mb_clr;

    dpr_port_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .cs_n     (cs_n_a[p]),
      .we_n     (we_n_a[p]),
      .oe_n     (oe_n_a[p]),
      .ub_n     (ub_n_a[p]),
      .lb_n     (lb_n_a[p]),
      .mem_q    (q_a[p]),
      .wr_lanes (wr_lanes_a[p]),
      .rd_lanes (rd_lanes_a[p]),
      .rdata    (rdata_a[p]),
      .drive    (drive_a[p])
    );

    assign mb_set = (|wr_lanes_a[OTHER]) && (addr_a[OTHER] == mbox_a[p]);
    assign mb_clr = (|rd_lanes_a[p])     && (addr_a[p]     == mbox_a[p]);

    dpr_mbox_flag u_flag (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set   (mb_set),
      .clr   (mb_clr),
      .irq_n (irq_n_a[p])
    );
  end

  dpr_mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .l_addr  (l_addr),
    .l_wdata (l_wdata),
    .l_wr    (wr_lanes_a[0]),
    .l_rd    (|rd_lanes_a[0]),
    .l_q     (q_a[0]),
    .r_addr  (r_addr),
    .r_wdata (r_wdata),
    .r_wr    (wr_lanes_a[1]),
    .r_rd    (|rd_lanes_a[1]),
    .r_q     (q_a[1])
  );

  assign l_rdata = rdata_a[0];
  assign r_rdata = rdata_a[1];
  assign l_drive = drive_a[0];
  assign r_drive = drive_a[1];
  assign l_irq_n = irq_n_a[0];
  assign r_irq_n = irq_n_a[1];

  // R6: the left interrupt only falls after a right write to its mailbox
  p_l_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(l_irq_n) |-> $past((|wr_lanes_a[1]) && (r_addr == MBOX_TO_L)));
  // R7: the right interrupt only rises after a right read of its mailbox
  p_r_irq_release_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(r_irq_n) |-> $past((|rd_lanes_a[1]) && (r_addr == MBOX_TO_R)));
endmodule

// File: tb/tb_dpram_mailbox.sv
`timescale 1ns/1ps
module tb_dpram_mailbox;
  localparam int AW  = 5;
  localparam int DEP = 1 << AW;
  localparam logic [AW-1:0] MB_L = AW'(DEP - 2);
  localparam logic [AW-1:0] MB_R = AW'(DEP - 1);

  logic clk = 1'b0;
  logic rst_n;
  logic l_cs_n, l_we_n, l_oe_n, l_ub_n, l_lb_n;
  logic r_cs_n, r_we_n, r_oe_n, r_ub_n, r_lb_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic [1:0] l_drive, r_drive;
  logic l_irq_n, r_irq_n;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] model [DEP];

  always #5 clk = ~clk;

  dpram_mailbox #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_ub_n(l_ub_n), .l_lb_n(l_lb_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_drive(l_drive), .l_irq_n(l_irq_n),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_ub_n(r_ub_n), .r_lb_n(r_lb_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_drive(r_drive), .r_irq_n(r_irq_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_l(input logic cs, input logic we, input logic ub, input logic lb,
                       input logic [AW-1:0] a, input logic [15:0] d);
    l_cs_n = cs; l_we_n = we; l_ub_n = ub; l_lb_n = lb; l_addr = a; l_wdata = d;
  endtask

  task automatic set_r(input logic cs, input logic we, input logic ub, input logic lb,
                       input logic [AW-1:0] a, input logic [15:0] d);
    r_cs_n = cs; r_we_n = we; r_ub_n = ub; r_lb_n = lb; r_addr = a; r_wdata = d;
  endtask

  task automatic idle();
    set_l(1, 1, 1, 1, '0, '0);
    set_r(1, 1, 1, 1, '0, '0);
  endtask

  task automatic mwrite(input logic [AW-1:0] a, input logic ub, input logic lb, input logic [15:0] d);
    if (!ub) model[a][15:8] = d[15:8];
    if (!lb) model[a][7:0]  = d[7:0];
  endtask

  function automatic logic [15:0] masked(input logic [15:0] w, input logic ub, input logic lb);
    return {ub ? 8'h00 : w[15:8], lb ? 8'h00 : w[7:0]};
  endfunction

  function automatic logic [15:0] pat(input int a, input int k);
    return 16'(a * 16'h0913 + k * 16'h2468 + 16'h05A1);
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    l_oe_n = 1'b0; r_oe_n = 1'b0;
    idle();
    #1;
    // R10: reset state
    chk("R10 l_irq_n", 16'(l_irq_n), 16'h1);
    chk("R10 r_irq_n", 16'(r_irq_n), 16'h1);
    chk("R10 l_drive", 16'(l_drive), 16'h0);
    chk("R10 r_rdata", r_rdata, 16'h0);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R10 l_irq_n after release", 16'(l_irq_n), 16'h1);
    chk("R10 r_drive after release", 16'(r_drive), 16'h0);

    // R1: full-word writes from left, read back on right
    for (int a = 0; a < DEP - 2; a++) begin
      set_l(0, 0, 0, 0, AW'(a), pat(a, 0));
      mwrite(AW'(a), 0, 0, pat(a, 0));
      tick();
      idle();
    end
    for (int a = 0; a < DEP - 2; a++) begin
      set_r(0, 1, 0, 0, AW'(a), '0);
      tick();
      chk("R1 right read data", r_rdata, model[a]);
      chk("R1 right drive", 16'(r_drive), 16'h3);
      idle();
    end

    // R2/R3: every write-select and read-select pairing
    for (int a = 0; a < DEP - 2; a += 3) begin
      for (int w = 0; w < 4; w++) begin
        set_r(0, 0, w[1], w[0], AW'(a), pat(a, w + 1));
        mwrite(AW'(a), w[1], w[0], pat(a, w + 1));
        tick();
        idle();
        for (int rc = 0; rc < 4; rc++) begin
          set_l(0, 1, rc[1], rc[0], AW'(a), '0);
          tick();
          chk("R2 R3 lane data", l_rdata, masked(model[a], rc[1], rc[0]));
          chk("R3 lane drive", 16'(l_drive), 16'({~rc[1], ~rc[0]}));
          idle();
        end
      end
    end

    // R4: output enable gating
    l_oe_n = 1'b1;
    set_l(0, 1, 0, 0, AW'(1), '0);
    tick();
    idle();
    chk("R4 oe high data", l_rdata, 16'h0);
    chk("R4 oe high drive", 16'(l_drive), 16'h0);
    l_oe_n = 1'b0;
    #1;
    chk("R4 oe low data", l_rdata, model[1]);
    chk("R4 oe low drive", 16'(l_drive), 16'h3);
    set_l(0, 0, 0, 0, AW'(3), 16'hBEEF);
    mwrite(AW'(3), 0, 0, 16'hBEEF);
    tick();
    idle();
    chk("R4 write cycle drive", 16'(l_drive), 16'h0);

    // R5: deselected port
    set_l(1, 0, 0, 0, AW'(2), ~model[2]);
    tick();
    idle();
    set_l(1, 1, 0, 0, AW'(2), '0);
    tick();
    chk("R5 deselected read drive", 16'(l_drive), 16'h0);
    idle();
    set_r(0, 1, 0, 0, AW'(2), '0);
    tick();
    chk("R5 deselected write ignored", r_rdata, model[2]);
    idle();
    set_r(1, 0, 0, 0, MB_L, 16'h1111);
    tick();
    idle();
    chk("R5 deselected mailbox write", 16'(l_irq_n), 16'h1);

    // R6/R8: left mailbox
    set_l(0, 0, 0, 0, MB_L, 16'h2222);
    mwrite(MB_L, 0, 0, 16'h2222);
    tick();
    idle();
    chk("R6 own write no set", 16'(l_irq_n), 16'h1);
    set_r(0, 0, 1, 0, MB_L, 16'hA55A);
    mwrite(MB_L, 1, 0, 16'hA55A);
    tick();
    idle();
    chk("R6 right write sets", 16'(l_irq_n), 16'h0);
    set_r(0, 1, 0, 0, MB_L, '0);
    tick();
    chk("R8 mailbox data right", r_rdata, model[MB_L]);
    idle();
    chk("R6 right read no clear", 16'(l_irq_n), 16'h0);
    set_l(0, 1, 0, 0, MB_L, '0);
    tick();
    chk("R8 mailbox data left", l_rdata, model[MB_L]);
    chk("R6 left read clears", 16'(l_irq_n), 16'h1);
    idle();

    // R7/R8: right mailbox
    set_r(0, 0, 0, 0, MB_R, 16'h3333);
    mwrite(MB_R, 0, 0, 16'h3333);
    tick();
    idle();
    chk("R7 own write no set", 16'(r_irq_n), 16'h1);
    set_l(0, 0, 0, 1, MB_R, 16'h7E81);
    mwrite(MB_R, 0, 1, 16'h7E81);
    tick();
    idle();
    chk("R7 left write sets", 16'(r_irq_n), 16'h0);
    set_l(0, 1, 0, 0, MB_R, '0);
    tick();
    chk("R8 right mailbox via left", l_rdata, model[MB_R]);
    idle();
    chk("R7 left read no clear", 16'(r_irq_n), 16'h0);
    set_r(0, 1, 0, 0, MB_R, '0);
    tick();
    chk("R8 right mailbox via right", r_rdata, model[MB_R]);
    chk("R7 right read clears", 16'(r_irq_n), 16'h1);
    idle();

    // R9: set and clear in one cycle
    set_l(0, 1, 0, 0, MB_L, '0);
    set_r(0, 0, 0, 0, MB_L, 16'h4C4C);
    tick();
    chk("R9 set wins left", 16'(l_irq_n), 16'h0);
    chk("R12 read during write", l_rdata, model[MB_L]);
    mwrite(MB_L, 0, 0, 16'h4C4C);
    idle();
    set_r(0, 1, 0, 0, MB_R, '0);
    set_l(0, 0, 0, 0, MB_R, 16'h5D5D);
    tick();
    chk("R9 set wins right", 16'(r_irq_n), 16'h0);
    mwrite(MB_R, 0, 0, 16'h5D5D);
    idle();
    set_l(0, 1, 0, 0, MB_L, '0);
    tick();
    idle();
    chk("R6 clear after R9", 16'(l_irq_n), 16'h1);

    // R11: same-cycle writes to one word
    set_l(0, 0, 0, 0, AW'(5), 16'hAAAA);
    set_r(0, 0, 0, 0, AW'(5), 16'hBBBB);
    tick();
    idle();
    set_r(0, 1, 0, 0, AW'(5), '0);
    tick();
    chk("R11 full overlap", r_rdata, 16'hAAAA);
    idle();
    set_l(0, 0, 0, 1, AW'(6), 16'hC1C1);
    set_r(0, 0, 1, 0, AW'(6), 16'hD2D2);
    tick();
    idle();
    set_r(0, 1, 0, 0, AW'(6), '0);
    tick();
    chk("R11 disjoint lanes", r_rdata, 16'hC1D2);
    idle();
    set_l(0, 0, 0, 1, AW'(8), 16'hE3E3);
    set_r(0, 0, 0, 0, AW'(8), 16'hF4F4);
    tick();
    idle();
    set_l(0, 1, 0, 0, AW'(8), '0);
    tick();
    chk("R11 partial overlap", l_rdata, 16'hE3F4);
    idle();

    // R12: read against a write on the other port
    set_l(0, 0, 0, 0, AW'(7), 16'h0F0F);
    set_r(0, 1, 0, 0, AW'(7), '0);
    tick();
    chk("R12 old data", r_rdata, model[7]);
    mwrite(AW'(7), 0, 0, 16'h0F0F);
    idle();
    set_r(0, 1, 0, 0, AW'(7), '0);
    tick();
    chk("R12 new data next read", r_rdata, model[7]);
    idle();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule